// File: doc/BRIEF.md
# Timer Control Register Bank

This block is the shared control bank that sits beside the channels of a multi-channel timer/counter unit. It keeps four bit-vector registers: per-channel counter enables, clock-stop bits (one per channel plus one that halts the watchdog clock), interrupt event flags, and interrupt masks. Software reaches each register through one read address and two write aliases. Writing ones to the set alias turns bits on, and writing ones to the clear alias turns bits off. No read-modify-write sequence is needed to touch a single channel.

Each channel reports two match events, "full" and "half", which the bank latches into separate flag bits. A single interrupt line is raised while any flag is set and not masked. The counting and waveform logic of the channels is outside this block. It consumes the enable and stop outputs and produces the event pulses.

Top module: `tmr_ctl_bank`

## Requirements
- R1: After reset the enable, stop, flag and mask registers are all zero, so every source is unmasked, all channel outputs are low and irq_o is low.
- R2: A write to a set alias (enable 0x14, stop 0x2C, flag 0x24, mask 0x34) sets exactly the bits written as 1 and leaves every other bit unchanged.
- R3: A write to a clear alias (enable 0x18, stop 0x3C, flag 0x28, mask 0x38) clears exactly the bits written as 1 and leaves every other bit unchanged.
- R4: With rd_en_i high, rdata_o shows the current register value for the read addresses (enable 0x10, stop 0x1C, flag 0x20, mask 0x30) in the same cycle. Set and clear aliases and unmapped addresses read 0, and rdata_o is 0 while rd_en_i is low.
- R5: Writes to the read addresses or to unmapped addresses change no register.
- R6: ch_en_o[n] is enable bit n and ch_stop_o[n] is stop bit n. wdt_stop_o is stop bit 16, where 1 halts the watchdog clock. Bits with no channel behind them always read 0.
- R7: full_evt_i[n] sets flag bit n, and half_evt_i[n] sets flag bit n+16, in the cycle after the pulse. The mask bits use the same bit positions.
- R8: When an event and a clear-alias write hit the same flag bit in the same cycle, the flag ends up set.
- R9: irq_o is high, combinationally, exactly while some flag bit is 1 and the mask bit at the same position is 0.
- R10: Mask bits suppress only irq_o. Events still latch into masked flag bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational |
| full_evt_i | input | N_CH | Per-channel full-match event pulses |
| half_evt_i | input | N_CH | Per-channel half-match event pulses |
| ch_en_o | output | N_CH | Per-channel counter enables |
| ch_stop_o | output | N_CH | Per-channel clock stops |
| wdt_stop_o | output | 1 | Watchdog clock stop |
| irq_o | output | 1 | Combined unmasked interrupt |

## Verification
A register bit that flips in the wrong direction shows up on ch_en_o, ch_stop_o or wdt_stop_o on the first edge after the write. The bench catches it by reading all four registers back after every operation. A lost event or a flag clear that wins over an event reaches irq_o and the flag readback one cycle after the pulse. A mask bit at the wrong position shows as irq_o high while every source is meant to be masked. Address decode faults show as a register changing after a write to a read-only or unmapped address, or as non-zero data read from an alias.

// File: rtl/tmr_ctl_pkg.sv
package tmr_ctl_pkg;
  localparam int unsigned DW     = 32;
  localparam int unsigned AW     = 8;
  localparam int unsigned N_REG  = 4;
  localparam int unsigned HALF_LSB = 16;
  localparam int unsigned WDT_BIT  = 16;

  typedef enum logic [1:0] {
    REG_EN   = 2'd0,
    REG_STOP = 2'd1,
    REG_FLAG = 2'd2,
    REG_MASK = 2'd3
  } reg_id_e;

  typedef struct packed {
    logic [AW-1:0] rd;
    logic [AW-1:0] set;
    logic [AW-1:0] clr;
  } reg_addr_t;

  function automatic reg_addr_t reg_addr(int unsigned idx);
    case (idx)
      0:       return '{rd: 8'h10, set: 8'h14, clr: 8'h18};
      1:       return '{rd: 8'h1C, set: 8'h2C, clr: 8'h3C};
      2:       return '{rd: 8'h20, set: 8'h24, clr: 8'h28};
      default: return '{rd: 8'h30, set: 8'h34, clr: 8'h38};
    endcase
  endfunction

  // Bits that exist in each register for a given channel count (nch <= 16)
  function automatic logic [DW-1:0] impl_mask(int unsigned idx, int unsigned nch);
    logic [DW-1:0] lo;
    lo = (DW'(1) << nch) - DW'(1);
    case (idx)
      0:       return lo;
      1:       return lo | (DW'(1) << WDT_BIT);
      default: return lo | (lo << HALF_LSB);
    endcase
  endfunction
endpackage

// File: rtl/tmr_ctl_decode.sv
module tmr_ctl_decode
  import tmr_ctl_pkg::*;
(
  input  logic                      wr_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [N_REG-1:0][DW-1:0]  set_o,
  output logic [N_REG-1:0][DW-1:0]  clr_o
);
  for (genvar g = 0; g < N_REG; g++) begin : g_dec
    localparam reg_addr_t RA = reg_addr(g);
    logic hit_set, hit_clr;
    assign hit_set  = wr_en_i && (addr_i == RA.set);
    assign hit_clr  = wr_en_i && (addr_i == RA.clr);
    assign set_o[g] = hit_set ? wdata_i : '0;
    assign clr_o[g] = hit_clr ? wdata_i : '0;
  end
endmodule

// File: rtl/tmr_ctl_sc_reg.sv
module tmr_ctl_sc_reg #(
  parameter int unsigned         W    = 32,
  parameter logic [W-1:0]        IMPL = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;

  // Hardware set is applied after software clear so a coincident event wins
  always_comb q_d = (((q_o & ~clr_i) | set_i) | hw_set_i) & IMPL;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= q_d;
  end
endmodule

// File: rtl/tmr_ctl_rdmux.sv
module tmr_ctl_rdmux
  import tmr_ctl_pkg::*;
(
  input  logic                      rd_en_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [N_REG-1:0][DW-1:0]  q_i,
  output logic [DW-1:0]             rdata_o
);
  logic [N_REG-1:0][DW-1:0] sel;

  for (genvar g = 0; g < N_REG; g++) begin : g_sel
    localparam reg_addr_t RA = reg_addr(g);
    assign sel[g] = (rd_en_i && (addr_i == RA.rd)) ? q_i[g] : '0;
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_REG; i++) rdata_o |= sel[i];
  end
endmodule

// File: rtl/tmr_ctl_bank.sv
module tmr_ctl_bank
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [7:0]      addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [N_CH-1:0] full_evt_i,
  input  logic [N_CH-1:0] half_evt_i,
  output logic [N_CH-1:0] ch_en_o,
  output logic [N_CH-1:0] ch_stop_o,
  output logic            wdt_stop_o,
  output logic            irq_o
);
  logic [N_REG-1:0][DW-1:0] set_w, clr_w, hw_w, q_w;
  logic [DW-1:0]            evt_vec;
  logic [DW-1:0]            en_q, stop_q, flag_q, mask_q;

  always_comb begin
    evt_vec = '0;
    evt_vec[N_CH-1:0]          = full_evt_i;
    evt_vec[HALF_LSB +: N_CH]  = half_evt_i;
  end

  tmr_ctl_decode u_dec (
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .set_o   (set_w),
    .clr_o   (clr_w)
  );

  for (genvar g = 0; g < N_REG; g++) begin : g_reg
    localparam logic [DW-1:0] IMPL = impl_mask(g, N_CH);
    if (g == int'(REG_FLAG)) begin : g_hw
      assign hw_w[g] = evt_vec;
    end else begin : g_sw
      assign hw_w[g] = '0;
    end
    tmr_ctl_sc_reg #(.W(DW), .IMPL(IMPL)) u_reg (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_i    (set_w[g]),
      .clr_i    (clr_w[g]),
      .hw_set_i (hw_w[g]),
      .q_o      (q_w[g])
    );
  end

  assign en_q   = q_w[REG_EN];
  assign stop_q = q_w[REG_STOP];
  assign flag_q = q_w[REG_FLAG];
  assign mask_q = q_w[REG_MASK];

  tmr_ctl_rdmux u_rd (
    .rd_en_i (rd_en_i),
    .addr_i  (addr_i),
    .q_i     (q_w),
    .rdata_o (rdata_o)
  );

  assign ch_en_o    = en_q[N_CH-1:0];
  assign ch_stop_o  = stop_q[N_CH-1:0];
  assign wdt_stop_o = stop_q[WDT_BIT];
  assign irq_o      = |(flag_q & ~mask_q);
endmodule

// File: rtl/tmr_ctl_chk.sv
module tmr_ctl_chk
  import tmr_ctl_pkg::*;
#(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [7:0]      addr_i,
  input logic [31:0]     wdata_i,
  input logic [31:0]     rdata_o,
  input logic [N_CH-1:0] full_evt_i,
  input logic [N_CH-1:0] half_evt_i,
  input logic            irq_o,
  input logic [31:0]     en_q,
  input logic [31:0]     stop_q,
  input logic [31:0]     flag_q,
  input logic [31:0]     mask_q
);
  localparam logic [31:0] EN_IMPL   = impl_mask(0, N_CH);
  localparam logic [31:0] FLAG_IMPL = impl_mask(2, N_CH);

  p_en_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h14) |=>
      ((en_q & $past(wdata_i & EN_IMPL)) == $past(wdata_i & EN_IMPL)));

  p_en_clr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 8'h18) |=> ((en_q & $past(wdata_i)) == '0));

  p_rd_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));

  p_en_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(en_q));

  p_stop_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(stop_q));

  p_full_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_evt_i != '0) |=>
      ((flag_q[N_CH-1:0] & $past(full_evt_i)) == $past(full_evt_i)));

  p_half_latch_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (half_evt_i != '0) |=>
      ((flag_q[HALF_LSB +: N_CH] & $past(half_evt_i)) == $past(half_evt_i)));

  p_irq_src_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flag_q != '0));

  p_all_masked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mask_q & FLAG_IMPL) == FLAG_IMPL) |-> !irq_o);

  p_mask_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q));
endmodule

bind tmr_ctl_bank tmr_ctl_chk #(.N_CH(N_CH)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rdata_o    (rdata_o),
  .full_evt_i (full_evt_i),
  .half_evt_i (half_evt_i),
  .irq_o      (irq_o),
  .en_q       (en_q),
  .stop_q     (stop_q),
  .flag_q     (flag_q),
  .mask_q     (mask_q)
);

// File: tb/tmr_ctl_bank_tb.sv
`timescale 1ns/1ps
module tmr_ctl_bank_tb;
  localparam int unsigned N = 8;
  localparam logic [31:0] LO        = (32'd1 << N) - 32'd1;
  localparam logic [31:0] EN_IMPL   = LO;
  localparam logic [31:0] STOP_IMPL = LO | 32'h0001_0000;
  localparam logic [31:0] FLAG_IMPL = LO | (LO << 16);

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] addr_i = '0;
  logic [31:0] wdata_i = '0, rdata_o;
  logic [N-1:0] full_evt_i = '0, half_evt_i = '0;
  logic [N-1:0] ch_en_o, ch_stop_o;
  logic wdt_stop_o, irq_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] m_en = '0, m_stp = '0, m_flg = '0, m_msk = '0;

  always #10 clk_i = ~clk_i;

  tmr_ctl_bank #(.N_CH(N)) u_dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One clock with a bus op and event pulses; model updated after the edge
  task automatic step(logic wr, logic [7:0] a, logic [31:0] d,
                      logic [N-1:0] fe, logic [N-1:0] he);
    logic [31:0] ev;
    @(negedge clk_i);
    wr_en_i = wr; addr_i = a; wdata_i = d; full_evt_i = fe; half_evt_i = he;
    @(posedge clk_i);
    #1;
    if (wr) begin
      case (a)
        8'h14: m_en  |= d;   8'h18: m_en  &= ~d;
        8'h2C: m_stp |= d;   8'h3C: m_stp &= ~d;
        8'h24: m_flg |= d;   8'h28: m_flg &= ~d;
        8'h34: m_msk |= d;   8'h38: m_msk &= ~d;
        default: ;
      endcase
    end
    ev = {16'(he), 16'(fe)};
    m_flg = (m_flg | ev) & FLAG_IMPL;
    m_en &= EN_IMPL; m_stp &= STOP_IMPL; m_msk &= FLAG_IMPL;
    wr_en_i = 0; full_evt_i = '0; half_evt_i = '0;
  endtask

  task automatic rd(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk_i);
    rd_en_i = 1; addr_i = a;
    #1 chk(req, rdata_o, exp);
    rd_en_i = 0;
  endtask

  task automatic check_all(string tag);
    rd({tag, " R4 en"},   8'h10, m_en);
    rd({tag, " R4 stop"}, 8'h1C, m_stp);
    rd({tag, " R4 flag"}, 8'h20, m_flg);
    rd({tag, " R4 mask"}, 8'h30, m_msk);
    chk({tag, " R6 ch_en"},   32'(ch_en_o),   m_en & LO);
    chk({tag, " R6 ch_stop"}, 32'(ch_stop_o), m_stp & LO);
    chk({tag, " R6 wdt"},     32'(wdt_stop_o), 32'(m_stp[16]));
    chk({tag, " R9 irq"},     32'(irq_o), 32'(|(m_flg & ~m_msk)));
  endtask

  function automatic logic [7:0] pick_addr(int unsigned k);
    case (k % 16)
      0: return 8'h10;  1: return 8'h14;  2: return 8'h18;  3: return 8'h1C;
      4: return 8'h2C;  5: return 8'h3C;  6: return 8'h20;  7: return 8'h24;
      8: return 8'h28;  9: return 8'h30; 10: return 8'h34; 11: return 8'h38;
      12: return 8'h00; 13: return 8'h40; 14: return 8'hFC; default: return 8'h2F;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk_i);
    #3 rst_ni = 1;
    // R1 reset state
    check_all("R1 reset");

    // R2 / R3 enable set then partial clear
    step(1, 8'h14, 32'hFFFF_FFFF, '0, '0);
    rd("R2 en set", 8'h10, 32'h0000_00FF);
    step(1, 8'h18, 32'h0000_000F, '0, '0);
    rd("R3 en clr", 8'h10, 32'h0000_00F0);
    // R6 stop set: only channel bits and watchdog bit exist
    step(1, 8'h2C, 32'hFFFF_FFFF, '0, '0);
    rd("R6 stop bits", 8'h1C, 32'h0001_00FF);
    chk("R6 wdt stop", 32'(wdt_stop_o), 32'd1);
    step(1, 8'h3C, 32'h0001_0000, '0, '0);
    chk("R6 wdt run", 32'(wdt_stop_o), 32'd0);
    // R5 writes to read and unmapped addresses ignored
    step(1, 8'h10, 32'h0000_000F, '0, '0);
    step(1, 8'h30, 32'hFFFF_FFFF, '0, '0);
    step(1, 8'h44, 32'hFFFF_FFFF, '0, '0);
    check_all("R5 ignored");
    // R4 alias reads return 0
    rd("R4 alias set read", 8'h14, 32'h0);
    rd("R4 alias clr read", 8'h3C, 32'h0);
    // R7 full and half events
    step(0, 8'h00, 0, 8'h04, 8'h80);
    rd("R7 events", 8'h20, 32'h0080_0004);
    chk("R9 irq unmasked", 32'(irq_o), 32'd1);
    // R8 event beats a coincident clear
    step(1, 8'h28, 32'h0080_0004, 8'h04, 8'h00);
    rd("R8 event wins", 8'h20, 32'h0000_0004);
    // R10 masked flags still latch, R9 no irq when all masked
    step(1, 8'h34, 32'hFFFF_FFFF, '0, '0);
    step(0, 8'h00, 0, 8'h01, 8'h01);
    rd("R10 masked latch", 8'h20, 32'h0001_0005);
    chk("R9 irq masked", 32'(irq_o), 32'd0);
    step(1, 8'h38, 32'h0001_0000, '0, '0);
    chk("R9 irq unmask half0", 32'(irq_o), 32'd1);
    check_all("directed");

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] fe, he;
      fe = (($urandom % 4) == 0) ? N'($urandom) : '0;
      he = (($urandom % 4) == 0) ? N'($urandom) : '0;
      step(($urandom % 5) != 0, pick_addr($urandom), $urandom, fe, he);
      check_all("rand R2 R3 R7");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule